// File: doc/BRIEF.md
# Banked-Window Bus Proxy Bridge

This block lets an 8-bit secondary processor read and write single bytes on a 16-bit main-processor bus through a 32 KB window at the top of its own address space. The secondary processor never arbitrates for the main bus itself. When it strobes an address in the window, the bridge claims the main bus with a three-wire request/grant/acknowledge handshake and runs one main-bus cycle. It then hands the byte back, or commits the written byte, and lets the bus go. The secondary processor is stalled by a wait line for the whole operation.

A bank register provides the upper main-bus address bits, and the low fifteen bits of the secondary address pick the byte inside the bank. A DMA master may already own the main bus when the access arrives. In that case the bridge holds its request back until that master gives the bus up, and the secondary processor just stays in wait. Accesses below the window cause no main-bus activity at all. Every port signal is active-high. Any inversion to the board's polarity, and the tri-state buffers themselves, sit outside the block.

Top module: `bank_proxy_bridge`

## Requirements
- R1: An access starts a proxied cycle only when `sec_rd` or `sec_wr` is high and `sec_addr` bit 15 is 1 (0x8000 to 0xFFFF). Lower addresses never raise `sec_wait` or `mb_br`, and they run no main-bus cycle.
- R2: The main-bus byte address of a proxied cycle is the bank register value, taken from `bank_din` when `bank_ld` is high, placed above `sec_addr[14:0]`, so that byte address = bank × 32768 + (addr mod 32768). `mb_addr` carries its bits 23..1.
- R3: An even byte address strobes only `mb_uds` and uses data bits 15..8. An odd byte address strobes only `mb_lds` and uses bits 7..0. Read data returns on `sec_rdata` from the strobed lane.
- R4: If `mb_bgack_in` (another master owns the bus) is high when a window access arrives, `mb_br` stays low until `mb_bgack_in` has gone low.
- R5: `mb_br` is held until `mb_bg` is seen while `mb_bgack_in` is low. Then `mb_bgack_out` rises and `mb_br` drops. `mb_bgack_out` stays high through the whole cycle and falls in the cycle after the main-bus cycle ends.
- R6: `mb_as` is asserted only while `mb_bgack_out` is high, and `mb_as_oe` equals ownership: high exactly while the bridge holds the bus.
- R7: Once `mb_as` and a data strobe are asserted, they stay asserted until `mb_dtack` is sampled high, however many cycles that takes.
- R8: `sec_wait` is high in the same cycle a window access appears. It stays high until the proxied cycle has finished, and `sec_rdata` is valid from the cycle in which it falls.
- R9: A window access yields exactly one main-bus cycle. While the strobe is held after completion, `sec_wait` stays low and no new request is made. A new access needs the strobe to be released first.
- R10: A write drives `mb_rw` low and `mb_data_oe` high, and puts the byte on both lanes of `mb_wdata`. A read keeps `mb_rw` high and `mb_data_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_din | input | 9 | New bank value |
| sec_addr | input | 16 | Secondary-processor address |
| sec_rd | input | 1 | Secondary read strobe, held for the access |
| sec_wr | input | 1 | Secondary write strobe, held for the access |
| sec_wdata | input | 8 | Secondary write byte |
| sec_rdata | output | 8 | Byte returned by the last proxied read |
| sec_wait | output | 1 | Stall to the secondary processor |
| mb_br | output | 1 | Main-bus request |
| mb_bg | input | 1 | Main-bus grant |
| mb_bgack_in | input | 1 | Another master holds the main bus |
| mb_bgack_out | output | 1 | Bridge holds the main bus |
| mb_addr | output | 23 | Main-bus word address, byte-address bits 23..1 |
| mb_rw | output | 1 | High for read, low for write |
| mb_as | output | 1 | Address strobe |
| mb_as_oe | output | 1 | Drive enable for the address strobe |
| mb_uds | output | 1 | Upper-lane data strobe (even byte) |
| mb_lds | output | 1 | Lower-lane data strobe (odd byte) |
| mb_wdata | output | 16 | Write data, byte copied to both lanes |
| mb_data_oe | output | 1 | Drive enable for write data |
| mb_rdata | input | 16 | Read data from the main bus |
| mb_dtack | input | 1 | Main-bus cycle acknowledge |

## Verification
The bridge is driven with reads and writes at even and odd offsets in banks from 0 to the top bank. This separates the lane selection and the address composition from each other. Grant and acknowledge latencies are varied from zero to several cycles, which shows whether the cycle really waits for the handshake and for the acknowledge rather than running for a fixed time. An access issued while another master holds the bus shows whether the request is deferred. Below-window accesses show that no bus traffic results, and a strobe held after completion shows that no repeat request is made.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

  typedef enum logic [2:0] {
    ARB_IDLE  = 3'd0,
    ARB_DEFER = 3'd1,
    ARB_REQ   = 3'd2,
    ARB_OWN   = 3'd3,
    ARB_FIN   = 3'd4
  } arb_st_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_STRB = 2'd2,
    SEQ_END  = 2'd3
  } seq_st_t;

endpackage

// File: rtl/bpb_bank_reg.sv
module bpb_bank_reg #(
  parameter int BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [BANK_W-1:0] din,
  output logic [BANK_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= din;
  end

endmodule

// File: rtl/bpb_arbiter.sv
module bpb_arbiter
  import bpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic dma_hold,
  input  logic bus_grant,
  input  logic xfer_done,
  output logic br,
  output logic bgack,
  output logic xfer_go,
  output logic finished
);

  arb_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_IDLE:  if (acc_req) st_d = dma_hold ? ARB_DEFER : ARB_REQ;
      ARB_DEFER: if (!dma_hold) st_d = ARB_REQ;
      ARB_REQ:   if (bus_grant && !dma_hold) st_d = ARB_OWN;
      ARB_OWN:   if (xfer_done) st_d = ARB_FIN;
      ARB_FIN:   if (!acc_req) st_d = ARB_IDLE;
      default:   st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  assign br       = (st_q == ARB_REQ);
  assign bgack    = (st_q == ARB_OWN);
  assign finished = (st_q == ARB_FIN);
  assign xfer_go  = (st_q == ARB_REQ) && (st_d == ARB_OWN);

endmodule

// File: rtl/bpb_cycle_seq.sv
module bpb_cycle_seq
  import bpb_pkg::*;
#(
  parameter int MAIN_AW = 24,
  parameter int SEC_DW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  is_wr,
  input  logic [MAIN_AW-1:0]    byte_addr,
  input  logic [SEC_DW-1:0]     wbyte,
  input  logic                  dtack,
  input  logic [2*SEC_DW-1:0]   rdata,
  output logic [MAIN_AW-1:1]    addr,
  output logic                  as_o,
  output logic                  uds,
  output logic                  lds,
  output logic                  rw,
  output logic [2*SEC_DW-1:0]   wdata,
  output logic                  data_oe,
  output logic [SEC_DW-1:0]     rbyte,
  output logic                  done
);

  localparam int MB_DW = 2 * SEC_DW;

  // Even byte addresses sit on the upper lane, odd ones on the lower lane.
  function automatic logic [SEC_DW-1:0] lane_of(input logic [MB_DW-1:0] w,
                                                input logic odd);
    return odd ? w[SEC_DW-1:0] : w[MB_DW-1:SEC_DW];
  endfunction

  seq_st_t             st_q;
  logic [MAIN_AW-1:0]  addr_q;
  logic                wr_q;
  logic [SEC_DW-1:0]   wb_q;
  logic [SEC_DW-1:0]   rb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      wb_q   <= '0;
      rb_q   <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (go) begin
          addr_q <= byte_addr;
          wr_q   <= is_wr;
          wb_q   <= wbyte;
          st_q   <= SEQ_ADDR;
        end
        SEQ_ADDR: st_q <= SEQ_STRB;
        SEQ_STRB: if (dtack) begin
          if (!wr_q) rb_q <= lane_of(rdata, addr_q[0]);
          st_q <= SEQ_END;
        end
        SEQ_END:  st_q <= SEQ_IDLE;
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  logic strobing;
  logic active;
  assign strobing = (st_q == SEQ_STRB);
  assign active   = (st_q == SEQ_ADDR) || strobing;

  assign addr    = addr_q[MAIN_AW-1:1];
  assign as_o    = strobing;
  assign uds     = strobing && !addr_q[0];
  assign lds     = strobing &&  addr_q[0];
  assign rw      = !(wr_q && active);
  assign data_oe = wr_q && active;
  assign wdata   = {wb_q, wb_q};
  assign rbyte   = rb_q;
  assign done    = (st_q == SEQ_END);

endmodule

// File: rtl/bank_proxy_bridge.sv
module bank_proxy_bridge #(
  parameter int SEC_AW  = 16,
  parameter int MAIN_AW = 24,
  parameter int SEC_DW  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bank_ld,
  input  logic [MAIN_AW-SEC_AW:0]   bank_din,
  input  logic [SEC_AW-1:0]         sec_addr,
  input  logic                      sec_rd,
  input  logic                      sec_wr,
  input  logic [SEC_DW-1:0]         sec_wdata,
  output logic [SEC_DW-1:0]         sec_rdata,
  output logic                      sec_wait,
  output logic                      mb_br,
  input  logic                      mb_bg,
  input  logic                      mb_bgack_in,
  output logic                      mb_bgack_out,
  output logic [MAIN_AW-1:1]        mb_addr,
  output logic                      mb_rw,
  output logic                      mb_as,
  output logic                      mb_as_oe,
  output logic                      mb_uds,
  output logic                      mb_lds,
  output logic [2*SEC_DW-1:0]       mb_wdata,
  output logic                      mb_data_oe,
  input  logic [2*SEC_DW-1:0]       mb_rdata,
  input  logic                      mb_dtack
);

  localparam int WIN_W  = SEC_AW - 1;
  localparam int BANK_W = MAIN_AW - WIN_W;

  function automatic logic in_window(input logic [SEC_AW-1:0] a);
    return a[SEC_AW-1];
  endfunction

  function automatic logic [MAIN_AW-1:0] compose_addr(input logic [BANK_W-1:0] b,
                                                      input logic [SEC_AW-1:0] a);
    return {b, a[WIN_W-1:0]};
  endfunction

  // Named internal events, also watched by the checker.
  logic              sec_any;
  logic              win_hit;
  logic              xfer_go;
  logic              xfer_done;
  logic              arb_fin;
  logic [BANK_W-1:0] bank_q;

  assign sec_any = sec_rd || sec_wr;
  assign win_hit = sec_any && in_window(sec_addr);

  bpb_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .ld   (bank_ld),
    .din  (bank_din),
    .q    (bank_q)
  );

  bpb_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (win_hit),
    .dma_hold (mb_bgack_in),
    .bus_grant(mb_bg),
    .xfer_done(xfer_done),
    .br       (mb_br),
    .bgack    (mb_bgack_out),
    .xfer_go  (xfer_go),
    .finished (arb_fin)
  );

  bpb_cycle_seq #(.MAIN_AW(MAIN_AW), .SEC_DW(SEC_DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (xfer_go),
    .is_wr    (sec_wr),
    .byte_addr(compose_addr(bank_q, sec_addr)),
    .wbyte    (sec_wdata),
    .dtack    (mb_dtack),
    .rdata    (mb_rdata),
    .addr     (mb_addr),
    .as_o     (mb_as),
    .uds      (mb_uds),
    .lds      (mb_lds),
    .rw       (mb_rw),
    .wdata    (mb_wdata),
    .data_oe  (mb_data_oe),
    .rbyte    (sec_rdata),
    .done     (xfer_done)
  );

  assign sec_wait = win_hit && !arb_fin;
  assign mb_as_oe = mb_bgack_out;

endmodule

// File: rtl/bpb_checker.sv
module bpb_checker (
  input logic clk,
  input logic rst_n,
  input logic sec_any,
  input logic sec_win,
  input logic sec_wait,
  input logic mb_br,
  input logic mb_bg,
  input logic mb_bgack_in,
  input logic mb_bgack_out,
  input logic mb_as,
  input logic mb_as_oe,
  input logic mb_uds,
  input logic mb_lds,
  input logic mb_dtack,
  input logic xfer_go,
  input logic xfer_done
);

  a_r1_outside_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_any && !sec_win) |-> !sec_wait);

  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mb_uds, mb_lds}));

  a_r3_lane_with_as: assert property (@(posedge clk) disable iff (!rst_n)
    mb_as |-> (mb_uds || mb_lds));

  a_r4_req_after_dma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mb_br) |-> !$past(mb_bgack_in));

  a_r5_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mb_bgack_out) |-> ($past(mb_bg) && $past(mb_br)));

  a_r5_no_br_while_own: assert property (@(posedge clk) disable iff (!rst_n)
    mb_bgack_out |-> !mb_br);

  a_r5_go_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> mb_bgack_out);

  a_r5_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !mb_bgack_out);

  a_r6_as_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
    mb_as |-> (mb_as_oe && mb_bgack_out));

  a_r7_hold_until_dtack: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_as && !mb_dtack) |=> mb_as);

  a_r8_wait_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_bgack_out && sec_win) |-> sec_wait);

  a_r9_no_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_win && $past(sec_win) && !sec_wait && !$past(sec_wait)) |-> !mb_br);

endmodule

bind bank_proxy_bridge bpb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_any     (sec_any),
  .sec_win     (win_hit),
  .sec_wait    (sec_wait),
  .mb_br       (mb_br),
  .mb_bg       (mb_bg),
  .mb_bgack_in (mb_bgack_in),
  .mb_bgack_out(mb_bgack_out),
  .mb_as       (mb_as),
  .mb_as_oe    (mb_as_oe),
  .mb_uds      (mb_uds),
  .mb_lds      (mb_lds),
  .mb_dtack    (mb_dtack),
  .xfer_go     (xfer_go),
  .xfer_done   (xfer_done)
);

// File: tb/sim_bank_proxy_bridge.sv
module sim_bank_proxy_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_ld = 1'b0;
  logic [8:0]  bank_din = '0;
  logic [15:0] sec_addr = '0;
  logic        sec_rd = 1'b0;
  logic        sec_wr = 1'b0;
  logic [7:0]  sec_wdata = '0;
  logic [7:0]  sec_rdata;
  logic        sec_wait;
  logic        mb_br;
  logic        mb_bg = 1'b0;
  logic        mb_bgack_in = 1'b0;
  logic        mb_bgack_out;
  logic [23:1] mb_addr;
  logic        mb_rw;
  logic        mb_as;
  logic        mb_as_oe;
  logic        mb_uds;
  logic        mb_lds;
  logic [15:0] mb_wdata;
  logic        mb_data_oe;
  logic [15:0] mb_rdata = '0;
  logic        mb_dtack = 1'b0;

  always #10 clk = ~clk;

  bank_proxy_bridge u0 (.*);

  typedef struct {
    logic        wr;
    logic [23:0] baddr;
    logic [7:0]  wb;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   gnt_dly = 0;
  int   dt_dly = 0;
  int   br_rises = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench memory: the word held at a main-bus word address.
  function automatic logic [15:0] word_at(input logic [23:1] wa);
    return {wa[8:1], wa[16:9]} ^ {1'b0, wa[23:17], 8'h3C};
  endfunction

  // Main-CPU grant model.
  initial begin
    int  gcnt = 0;
    logic prev_br = 1'b0;
    forever begin
      @(negedge clk);
      if (mb_br && !prev_br) br_rises++;
      prev_br = mb_br;
      if (!rst_n || mb_bgack_out || !mb_br) begin
        mb_bg = 1'b0;
        gcnt  = 0;
      end else if (gcnt >= gnt_dly) begin
        mb_bg = 1'b1;
      end else begin
        gcnt++;
      end
    end
  end

  // Slave acknowledge model.
  initial begin
    int dcnt = 0;
    forever begin
      @(negedge clk);
      if (mb_as && (mb_uds || mb_lds)) begin
        if (dcnt >= dt_dly) begin
          mb_dtack = 1'b1;
          mb_rdata = word_at(mb_addr);
        end else begin
          dcnt++;
        end
      end else begin
        mb_dtack = 1'b0;
        dcnt     = 0;
      end
    end
  end

  // Monitor: pops one expected item per acknowledged main-bus cycle.
  initial begin
    bit   taken = 1'b0;
    int   as_cnt = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (mb_as) as_cnt++;
      else begin
        as_cnt = 0;
        taken  = 1'b0;
      end
      if (mb_as && mb_dtack && !taken) begin
        taken = 1'b1;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected main-bus cycle", {8'h0, mb_addr, 1'b0}, 0);
        end else begin
          e = sb_q.pop_front();
          chk(mb_addr == e.baddr[23:1], "R2", "word address", mb_addr, e.baddr[23:1]);
          chk(mb_uds == !e.baddr[0] && mb_lds == e.baddr[0], "R3", "lane strobes",
              {mb_uds, mb_lds}, {!e.baddr[0], e.baddr[0]});
          chk(mb_rw == !e.wr, "R10", "direction", mb_rw, !e.wr);
          chk(as_cnt == dt_dly + 1, "R7", "strobe cycles", as_cnt, dt_dly + 1);
          chk(mb_bgack_out && mb_as_oe, "R6", "ownership during strobe",
              {mb_bgack_out, mb_as_oe}, 2'b11);
          if (e.wr) begin
            chk(mb_data_oe && (e.baddr[0] ? mb_wdata[7:0] : mb_wdata[15:8]) == e.wb,
                "R10", "write lane data",
                e.baddr[0] ? mb_wdata[7:0] : mb_wdata[15:8], e.wb);
          end
        end
      end
    end
  end

  // Driver: one secondary access, with optional bus occupancy by another master.
  task automatic access(input logic [8:0] bank, input logic [15:0] a, input bit wr,
                        input logic [7:0] wb, input int hold, input int dma_cyc);
    exp_t        e;
    logic [23:0] ba;
    logic [15:0] w;
    int          rises0;
    @(negedge clk);
    bank_ld  = 1'b1;
    bank_din = bank;
    @(negedge clk);
    bank_ld = 1'b0;
    ba = 24'(bank) * 24'd32768 + 24'(a & 16'h7FFF);
    rises0 = br_rises;
    if (a >= 16'h8000) begin
      e.wr = wr; e.baddr = ba; e.wb = wb;
      sb_q.push_back(e);
    end
    if (dma_cyc > 0) mb_bgack_in = 1'b1;
    sec_addr = a; sec_wr = wr; sec_rd = !wr; sec_wdata = wb;
    #1;
    if (a >= 16'h8000) begin
      chk(sec_wait == 1'b1, "R8", "wait at access start", sec_wait, 1);
      if (dma_cyc > 0) begin
        repeat (dma_cyc) @(negedge clk);
        #1;
        chk(!mb_br && sec_wait && br_rises == rises0, "R4", "request held off by other master",
            {mb_br, sec_wait}, 2'b01);
        mb_bgack_in = 1'b0;
      end
      while (sec_wait) begin
        @(negedge clk);
        #1;
      end
      chk(!mb_bgack_out, "R5", "bus released at completion", mb_bgack_out, 0);
      chk(sb_q.size() == 0, "R9", "one main-bus cycle per access", sb_q.size(), 0);
      if (!wr) begin
        w = word_at(ba[23:1]);
        chk(sec_rdata == (ba[0] ? w[7:0] : w[15:8]), "R3", "read byte",
            sec_rdata, ba[0] ? w[7:0] : w[15:8]);
      end
      rises0 = br_rises;
      repeat (hold) @(negedge clk);
      #1;
      chk(!sec_wait && !mb_br && br_rises == rises0, "R9", "no repeat while strobe held",
          {sec_wait, mb_br}, 0);
    end else begin
      repeat (4) @(negedge clk);
      #1;
      chk(!sec_wait && br_rises == rises0, "R1", "below-window access inert",
          {sec_wait, 8'(br_rises - rises0)}, 0);
    end
    @(negedge clk);
    sec_rd = 1'b0; sec_wr = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk({mb_br, mb_bgack_out, mb_as_oe, mb_as, sec_wait} == 5'b0, "R6", "reset state",
        {mb_br, mb_bgack_out, mb_as_oe, mb_as, sec_wait}, 0);

    access(9'h000, 16'h8000, 1'b0, 8'h00, 1, 0);  // R2 bottom of window, even
    access(9'h003, 16'h8001, 1'b0, 8'h00, 1, 0);  // R3 odd lane read
    access(9'h055, 16'h9234, 1'b1, 8'hA7, 1, 0);  // R10 even write
    access(9'h1FF, 16'hFFFF, 1'b1, 8'h3C, 1, 0);  // R2 top bank, top byte
    access(9'h012, 16'h1234, 1'b0, 8'h00, 0, 0);  // R1 below window read
    access(9'h012, 16'h7FFF, 1'b1, 8'h99, 0, 0);  // R1 below window write
    gnt_dly = 3; dt_dly = 4;
    access(9'h0AA, 16'hC567, 1'b0, 8'h00, 1, 0);  // R5 R7 slow grant and acknowledge
    access(9'h101, 16'hABCE, 1'b1, 8'h5E, 1, 0);
    gnt_dly = 1; dt_dly = 2;
    access(9'h101, 16'hABCF, 1'b0, 8'h00, 1, 6);  // R4 defer to other master
    access(9'h0F0, 16'hE002, 1'b1, 8'hC1, 5, 3);  // R4 R9 write, long hold
    gnt_dly = 0; dt_dly = 0;
    access(9'h0F0, 16'hE002, 1'b0, 8'h00, 1, 0);
    access(9'h0F0, 16'hE003, 1'b0, 8'h00, 1, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule